// File: doc/BRIEF.md
# LDPC Decoder Iteration Controller

This controller runs the schedule of a partly parallel LDPC decoder for one code frame. A start request begins an initialization sweep, which copies the channel messages into the extrinsic stores. The controller then alternates check phases and variable phases. Every message RAM keeps variable node d at address d−1, so the controller drives one shared read address and one shared write address for all of them. It also drives a mode code that tells the datapath which operation to perform.

Writes trail reads by a fixed pipeline depth, so the write-back from the read, shuffle, modify, unshuffle and write loop lands at the same address it was read from. Each phase therefore covers L read cycles followed by a drain. During the write cycles of a check phase, the check units report per-cycle parity flags. These flags are gathered into a sticky failure bit. At the end of a check phase, a clean parity result ends the frame as converged. If no check phase comes back clean, the frame ends after the last allowed variable phase, unconverged.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: During and after reset the controller is idle: busy, rd_en, wr_en, done and converged are 0, mode is 0, and both addresses and iters are 0.
- R2: A start seen while idle begins the initialization phase on the next cycle. That phase has mode 1, busy is 1, and reads start at address 0 and count up by one per cycle.
- R3: Every phase lasts L+PIPE_DLY cycles. The mode codes are 1 for initialization, 2 for check and 3 for variable. Phases run in the order 1, 2, 3, 2, 3, and so on. rd_en is 1 with rd_addr equal to the cycle index for the first L cycles of a phase, and it is 0 for the rest.
- R4: wr_en is 1 from cycle PIPE_DLY to the last cycle of every phase. wr_addr equals the read address issued PIPE_DLY cycles earlier. Both addresses read 0 when their enable is low.
- R5: Parity flags (chk_ok, one bit per check unit, 1 meaning satisfied) are used only in check-phase cycles where wr_en is 1. Values at any other time do not change the outcome.
- R6: A 0 on any chk_ok bit in any sampled cycle of a check phase marks that phase failed, and this includes the first and the last sampled cycle. The mark does not carry into the next check phase.
- R7: When a check phase ends with no failure, done pulses on the next cycle with converged=1. At that point iters holds the number of variable phases completed in the frame, from 0 to MAX_ITER−1.
- R8: When MAX_ITER variable phases have completed without convergence, done pulses on the next cycle with converged=0 and iters=MAX_ITER.
- R9: done lasts exactly one cycle. converged and iters hold their values until the next accepted start. A start while busy is ignored. A start in the cycle done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| chk_ok | input | NCHK | Per-unit parity satisfied flags for the current write-back cycle |
| busy | output | 1 | A frame is in progress |
| mode | output | 2 | 0 idle, 1 init, 2 check, 3 variable |
| rd_en | output | 1 | Shared read enable |
| rd_addr | output | $clog2(L) | Shared read address |
| wr_en | output | 1 | Pipeline-aligned write enable |
| wr_addr | output | $clog2(L) | Write address, read address delayed PIPE_DLY |
| iters | output | $clog2(MAX_ITER+1) | Variable phases completed in this frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| converged | output | 1 | Frame ended with all checks satisfied |

## Verification
The assertions assume three things about the environment. start is a clean synchronous level. PIPE_DLY lies between 1 and L, so reads and write-backs overlap and the address difference stays positive. chk_ok is meaningful only in sampled cycles. The stimulus keeps within these limits: it uses a small L with a shorter delay, and it drives start only at clock midpoints. It also drives chk_ok to all-zero outside the sampled window on some frames, and it clears a single bit at chosen positions inside the window to place each failure exactly.

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
  parameter int L        = 256,
  parameter int PIPE_DLY = 4,
  parameter int MAX_ITER = 18,
  parameter int NCHK     = 18,
  localparam int AW      = $clog2(L),
  localparam int IW      = $clog2(MAX_ITER + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NCHK-1:0] chk_ok,
  output logic            busy,
  output logic [1:0]      mode,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [IW-1:0]   iters,
  output logic            done,
  output logic            converged
);

  localparam int PH = L + PIPE_DLY;
  localparam int CW = $clog2(PH);

  localparam logic [1:0] M_IDLE = 2'd0;
  localparam logic [1:0] M_INIT = 2'd1;
  localparam logic [1:0] M_CHK  = 2'd2;
  localparam logic [1:0] M_VAR  = 2'd3;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          fail;
  logic [IW-1:0] it;
  logic          done_q;
  logic          conv_q;

  wire last     = (cnt == CW'(PH - 1));
  wire active   = (st != M_IDLE);
  wire sample   = (st == M_CHK) && wr_en;
  wire fail_now = fail | (sample & ~&chk_ok);

  assign busy      = active;
  assign mode      = st;
  assign rd_en     = active && (cnt < CW'(L));
  assign wr_en     = active && (cnt >= CW'(PIPE_DLY));
  assign rd_addr   = rd_en ? AW'(cnt) : '0;
  assign wr_addr   = wr_en ? AW'(cnt - CW'(PIPE_DLY)) : '0;
  assign iters     = it;
  assign done      = done_q;
  assign converged = conv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      cnt    <= '0;
      fail   <= 1'b0;
      it     <= '0;
      done_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          st     <= M_INIT;
          cnt    <= '0;
          it     <= '0;
          conv_q <= 1'b0;
        end
      end else begin
        fail <= (st == M_CHK && cnt == '0) ? 1'b0 : fail_now;
        if (last) begin
          cnt <= '0;
          case (st)
            M_INIT: st <= M_CHK;
            M_CHK: begin
              if (!fail_now) begin
                st     <= M_IDLE;
                done_q <= 1'b1;
                conv_q <= 1'b1;
              end else begin
                st <= M_VAR;
              end
            end
            default: begin
              it <= it + 1'b1;
              if (it == IW'(MAX_ITER - 1)) begin
                st     <= M_IDLE;
                done_q <= 1'b1;
              end else begin
                st <= M_CHK;
              end
            end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && mode == $past(mode)));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mode == M_INIT && rd_en && rd_addr == '0));

  // R4
  wr_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (AW'(rd_addr - wr_addr) == AW'(PIPE_DLY)));

  // R3
  init_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_INIT && mode != M_INIT) |-> (mode == M_CHK));

  // R7
  conv_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && converged) |-> (iters < IW'(MAX_ITER)));

  // R8
  unconv_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !converged) |-> (iters == IW'(MAX_ITER)));

endmodule

// File: tb/tb_ldpc_iter_ctrl.sv
`timescale 1ns/1ps
module tb_ldpc_iter_ctrl;
  localparam int L  = 8;
  localparam int D  = 3;
  localparam int MX = 6;
  localparam int NC = 4;
  localparam int P  = L + D;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NC-1:0] chk_ok = '1;
  logic          busy, rd_en, wr_en, done, converged;
  logic [1:0]    mode;
  logic [2:0]    rd_addr, wr_addr;
  logic [2:0]    iters;

  ldpc_iter_ctrl #(.L(L), .PIPE_DLY(D), .MAX_ITER(MX), .NCHK(NC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_ok(chk_ok),
    .busy(busy), .mode(mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .iters(iters), .done(done),
    .converged(converged)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int m_st, m_cnt, m_it, m_fail, m_done, m_conv, m_cidx;
  int fu = 0, fpos = D, noise = 0;
  bit running = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_it = 0; m_fail = 0; m_done = 0; m_conv = 0; m_cidx = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (start) begin
          m_st = 1; m_cnt = 0; m_it = 0; m_conv = 0; m_cidx = 0;
        end
      end else begin
        if (m_st == 2 && m_cnt == 0) m_fail = 0;
        if (m_st == 2 && m_cnt >= D && chk_ok != '1) m_fail = 1;
        if (m_cnt == P - 1) begin
          m_cnt = 0;
          case (m_st)
            1: m_st = 2;
            2: if (!m_fail) begin m_st = 0; m_done = 1; m_conv = 1; end else m_st = 3;
            default: begin
              m_it++;
              if (m_it == MX) begin m_st = 0; m_done = 1; end
              else begin m_st = 2; m_cidx++; end
            end
          endcase
        end else m_cnt++;
      end
    end
  end

  // parity stimulus (R5, R6)
  always @(negedge clk) begin
    if (m_st == 2 && m_cnt >= D) begin
      logic [NC-1:0] v;
      v = '1;
      if (m_cidx < fu && m_cnt == fpos) v[m_cidx % NC] = 1'b0;
      chk_ok = v;
    end else begin
      chk_ok = noise ? '0 : '1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && running) begin
      int erd, ewr;
      erd = (m_st != 0 && m_cnt < L);
      ewr = (m_st != 0 && m_cnt >= D);
      check("R3 mode", mode, m_st);
      check("R2 busy", busy, m_st != 0);
      check("R3 rd_en", rd_en, erd);
      check("R3 rd_addr", rd_addr, erd ? m_cnt : 0);
      check("R4 wr_en", wr_en, ewr);
      check("R4 wr_addr", wr_addr, ewr ? m_cnt - D : 0);
      check("R9 done", done, m_done);
      check("R9 converged", converged, m_conv);
      check("R9 iters", iters, m_it);
    end
  end

  task automatic run_frame(input int fu_i, input int pos_i, input int noise_i, input bit poke);
    int cyc;
    bit exp_conv;
    fu = fu_i; fpos = pos_i; noise = noise_i;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!m_done) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 5);
    end
    start = 1'b0;
    exp_conv = (fu_i <= MX - 1);
    // R7 / R8 outcome derived from the scenario alone
    check(exp_conv ? "R7 final converged" : "R8 final converged", converged, exp_conv);
    check(exp_conv ? "R7 final iters" : "R8 final iters", iters, exp_conv ? fu_i : MX);
    check("R9 done at end", done, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 mode", mode, 0);
    check("R1 rd_en", rd_en, 0);
    check("R1 wr_en", wr_en, 0);
    check("R1 done", done, 0);
    check("R1 converged", converged, 0);
    check("R1 iters", iters, 0);
    check("R1 addr", rd_addr + wr_addr, 0);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    run_frame(0, D, 1, 0);        // R5 noise outside window, R7 zero iterations
    run_frame(2, D, 0, 1);        // R6 first sampled cycle, R9 start while busy
    run_frame(3, P - 1, 1, 0);    // R6 last sampled cycle
    repeat (3) @(negedge clk);
    run_frame(99, 5, 0, 0);       // R8 never converges
    run_frame(MX - 1, D + 1, 1, 0); // R7 converges at the final check
    run_frame(MX, 6, 0, 1);       // R8 boundary
    repeat (4) @(negedge clk);
    check("R9 idle after frame", busy, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule